// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side descriptor engine of an Ethernet MAC. Software keeps a ring of two-word buffer descriptors in memory. The block is given a stream of frame segments. Each segment is the part of a frame that fits one buffer, and it carries a byte count and first/last markers. For each segment the block does four things in order:

1. It fetches the current descriptor.
2. It checks that the hardware owns that descriptor.
3. It writes the segment's status into the descriptor.
4. It hands the descriptor back by setting its used flag, then moves to the next entry.

The descriptor memory is reached through a simple single-port interface. A read returns its data in the cycle after the request.

A frame may occupy several consecutive descriptors. Only the first is marked as a start and only the last is marked as an end. The ring ends at the descriptor whose wrap flag is set, and the next fetch goes back to the ring base. If the descriptor the block is about to fill still belongs to software, the block does not write it. Instead it raises a buffer-not-available flag and keeps polling that descriptor until software releases it.

Writing the base register moves the ring to a new place in memory and restarts at entry 0.

Top module: `rxd_ring_writer`

## Requirements
- R1: After reset, no memory read or write is issued, `seg_ready` and `no_buf` are 0, and the first descriptor fetched is at the ring base.
- R2: When a segment is pending and the block is idle, it issues one read of word 0 of the current descriptor at address base + 8*index. The read is issued in the cycle after the segment is first seen, and the read data is consumed in the cycle after the request.
- R3: For a descriptor it owns, the block first writes word 1 at descriptor address + 4. Word 1 carries the length in bits 13:0, the first-segment flag in bit 14 and the last-segment flag in bit 15, with bits 31:16 zero.
- R4: In the cycle after the word-1 write, the block writes word 0 back with bits 31:1 (buffer address and wrap flag) unchanged and bit 0 (used) set. In that same cycle `seg_ready` is 1 for exactly one cycle, which consumes the segment.
- R5: A descriptor whose word 0 has bit 0 set is never written. The block raises `no_buf` and re-reads the same descriptor every two cycles. `no_buf` clears when a free descriptor is read.
- R6: After filling a descriptor whose word 0 bit 1 (wrap) is set, the next descriptor is at the base. After entry RING_DEPTH-1 the ring wraps to the base even without the flag. Otherwise the index advances by one.
- R7: A write to the base register loads the base with bits 2:0 cleared and sets the index to 0. It also drops any descriptor still in progress, clears `no_buf`, and leaves no memory access and no `seg_ready` in the next cycle.
- R8: A segment length above BUF_BYTES (1536) is recorded in word 1 as BUF_BYTES.
- R9: A memory read and a memory write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base_wr | input | 1 | Base register write strobe |
| ring_base | input | AW | New ring base byte address |
| seg_valid | input | 1 | A segment is pending |
| seg_ready | output | 1 | Segment consumed this cycle |
| seg_len | input | 14 | Segment byte count |
| seg_first | input | 1 | Segment starts a frame |
| seg_last | input | 1 | Segment ends a frame |
| dm_rd | output | 1 | Descriptor memory read request |
| dm_wr | output | 1 | Descriptor memory write request |
| dm_addr | output | AW | Descriptor memory byte address |
| dm_wdata | output | 32 | Descriptor write data |
| dm_rdata | input | 32 | Read data, valid the cycle after `dm_rd` |
| no_buf | output | 1 | Buffer not available; waiting on a software-owned descriptor |

## Verification
The bench aims at four corner cases.

- **Reaching a descriptor software still owns.** The bench holds a segment against a used descriptor for many cycles. A design that ignored ownership would overwrite the previous frame's status. One that forgot to re-poll would hang after software releases the descriptor.
- **Wrapping.** The bench runs one ring that ends only by depth and a short ring that ends by its wrap flag. A wrong wrap rule shows up as an access outside the ring or as a write to a marker word placed after it.
- **Multi-segment frames and oversize lengths.** These check the start/end flag placement and the length clamp in word 1.
- **Base write during a stalled fetch.** This must restart at the new ring's entry 0 with the flag cleared, rather than completing the old descriptor.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

  // Descriptor layout: this is what software decodes, so positions are fixed
  localparam int DW        = 32;
  localparam int LEN_W     = 14;
  localparam int USED_BIT  = 0;
  localparam int WRAP_BIT  = 1;
  localparam int FIRST_BIT = 14;
  localparam int LAST_BIT  = 15;
  localparam int DESC_BYTES = 8;
  localparam int STAT_OFS   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDREQ,
    ST_RDWAIT,
    ST_WSTAT,
    ST_WOWN
  } rxd_state_e;

endpackage

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
  parameter int RING_DEPTH = 32,
  parameter int AW         = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_wr,
  input  logic [AW-1:0] base_in,
  input  logic          advance,
  input  logic          wrap_seen,
  output logic [AW-1:0] desc_addr
);
  localparam int IDX_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_DEPTH - 1);

  logic [AW-1:0]    base_q;
  logic [IDX_W-1:0] idx_q;
  logic             at_end;

  assign at_end = wrap_seen || (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (base_wr) begin
      base_q <= base_in & ~AW'(7);
      idx_q  <= '0;
    end else if (advance) begin
      idx_q <= at_end ? '0 : IDX_W'(idx_q + 1'b1);
    end
  end

  assign desc_addr = base_q + (AW'(idx_q) << 3);

  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST_IDX);

  // R7
  base_align_chk: assert property (@(posedge clk) disable iff (rst)
    desc_addr[2:0] == 3'b000);

endmodule

// File: rtl/rxd_status_fmt.sv
module rxd_status_fmt
  import rxd_pkg::*;
#(
  parameter int BUF_BYTES = 1536
) (
  input  logic [LEN_W-1:0] len_in,
  input  logic             first_in,
  input  logic             last_in,
  output logic [DW-1:0]    status_word
);
  logic [LEN_W-1:0] len_rec;

  generate
    if (BUF_BYTES < (1 << LEN_W)) begin : g_clamp
      always_comb begin
        len_rec = (len_in > LEN_W'(BUF_BYTES)) ? LEN_W'(BUF_BYTES) : len_in;
      end
    end else begin : g_pass
      always_comb begin
        len_rec = len_in;
      end
    end
  endgenerate

  always_comb begin
    status_word = '0;
    status_word[LEN_W-1:0] = len_rec;
    status_word[FIRST_BIT] = first_in;
    status_word[LAST_BIT]  = last_in;
  end

endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_wr,
  input  logic          seg_valid,
  input  logic [AW-1:0] desc_addr,
  input  logic [DW-1:0] status_word,
  input  logic [DW-1:0] rd_data,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          seg_ready,
  output logic          no_buf,
  output logic          advance,
  output logic          wrap_seen
);
  rxd_state_e    state;
  logic [DW-1:0] w0_q;

  always_ff @(posedge clk) begin
    if (rst || base_wr) begin
      state     <= ST_IDLE;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      seg_ready <= 1'b0;
      no_buf    <= 1'b0;
      w0_q      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (seg_valid) begin
            mem_rd   <= 1'b1;
            mem_addr <= desc_addr;
            state    <= ST_RDREQ;
          end
        end
        ST_RDREQ: begin
          mem_rd <= 1'b0;
          state  <= ST_RDWAIT;
        end
        ST_RDWAIT: begin
          if (rd_data[USED_BIT]) begin
            no_buf   <= 1'b1;
            mem_rd   <= 1'b1;
            mem_addr <= desc_addr;
            state    <= ST_RDREQ;
          end else begin
            no_buf    <= 1'b0;
            w0_q      <= rd_data;
            mem_wr    <= 1'b1;
            mem_addr  <= desc_addr + AW'(STAT_OFS);
            mem_wdata <= status_word;
            state     <= ST_WSTAT;
          end
        end
        ST_WSTAT: begin
          mem_addr  <= desc_addr;
          mem_wdata <= w0_q | DW'(1 << USED_BIT);
          seg_ready <= 1'b1;
          state     <= ST_WOWN;
        end
        ST_WOWN: begin
          mem_wr    <= 1'b0;
          seg_ready <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign advance   = (state == ST_WOWN);
  assign wrap_seen = w0_q[WRAP_BIT];

  // R5
  owned_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDWAIT && rd_data[USED_BIT] && !base_wr) |=> (!mem_wr && no_buf));

  // R4
  used_set_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_addr[2]) |-> mem_wdata[USED_BIT]);

  // R3
  stat_first_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_addr[2]) |-> $past(mem_wr && mem_addr[2]));

  // R4
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    seg_ready |=> !seg_ready);

  // R9
  one_access_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr}));

endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer
  import rxd_pkg::*;
#(
  parameter int RING_DEPTH = 32,
  parameter int BUF_BYTES  = 1536,
  parameter int AW         = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ring_base_wr,
  input  logic [AW-1:0]    ring_base,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [LEN_W-1:0] seg_len,
  input  logic             seg_first,
  input  logic             seg_last,
  output logic             dm_rd,
  output logic             dm_wr,
  output logic [AW-1:0]    dm_addr,
  output logic [DW-1:0]    dm_wdata,
  input  logic [DW-1:0]    dm_rdata,
  output logic             no_buf
);
  logic [AW-1:0] desc_addr;
  logic [DW-1:0] status_word;
  logic          advance;
  logic          wrap_seen;

  rxd_ring_ptr #(.RING_DEPTH(RING_DEPTH), .AW(AW)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .base_wr   (ring_base_wr),
    .base_in   (ring_base),
    .advance   (advance),
    .wrap_seen (wrap_seen),
    .desc_addr (desc_addr)
  );

  rxd_status_fmt #(.BUF_BYTES(BUF_BYTES)) u_fmt (
    .len_in      (seg_len),
    .first_in    (seg_first),
    .last_in     (seg_last),
    .status_word (status_word)
  );

  rxd_ctrl #(.AW(AW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .base_wr     (ring_base_wr),
    .seg_valid   (seg_valid),
    .desc_addr   (desc_addr),
    .status_word (status_word),
    .rd_data     (dm_rdata),
    .mem_rd      (dm_rd),
    .mem_wr      (dm_wr),
    .mem_addr    (dm_addr),
    .mem_wdata   (dm_wdata),
    .seg_ready   (seg_ready),
    .no_buf      (no_buf),
    .advance     (advance),
    .wrap_seen   (wrap_seen)
  );

  // R8
  len_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (dm_wr && dm_addr[2]) |-> (int'(dm_wdata[LEN_W-1:0]) <= BUF_BYTES));

  // R3
  stat_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (dm_wr && dm_addr[2]) |-> (dm_wdata[DW-1:16] == '0));

endmodule

// File: tb/sim_rxd_ring_writer.sv
module sim_rxd_ring_writer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        b_wr = 1'b0;
  logic [31:0] b_val = '0;
  logic        c_valid = 1'b0;
  logic [13:0] c_len = '0;
  logic        c_first = 1'b0;
  logic        c_last = 1'b0;
  logic        seg_ready, dm_rd, dm_wr, no_buf;
  logic [31:0] dm_addr, dm_wdata;
  logic [31:0] dm_rdata = '0;

  logic [31:0] mem [0:255];

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;

  always #10 clk = ~clk;

  rxd_ring_writer u0 (
    .clk(clk), .rst(rst), .ring_base_wr(b_wr), .ring_base(b_val),
    .seg_valid(c_valid), .seg_ready(seg_ready), .seg_len(c_len),
    .seg_first(c_first), .seg_last(c_last), .dm_rd(dm_rd), .dm_wr(dm_wr),
    .dm_addr(dm_addr), .dm_wdata(dm_wdata), .dm_rdata(dm_rdata), .no_buf(no_buf)
  );

  // descriptor RAM with one cycle read latency
  always @(posedge clk) begin
    if (dm_rd) dm_rdata <= mem[dm_addr[9:2]];
    if (dm_wr) mem[dm_addr[9:2]] <= dm_wdata;
  end

  // behavioural reference model, stepped every clock
  int          m_ph = 0;
  int          m_idx = 0;
  logic [31:0] m_base = '0;
  logic [31:0] m_snap = '0;
  logic        e_rd = 0, e_wr = 0, e_rdy = 0, e_bna = 0;
  logic [31:0] e_addr = '0, e_wd = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_idx = 0; m_base = '0;
      e_rd = 0; e_wr = 0; e_rdy = 0; e_bna = 0;
    end else if (b_wr) begin
      m_base = b_val & 32'hFFFF_FFF8; m_idx = 0; m_ph = 0;
      e_rd = 0; e_wr = 0; e_rdy = 0; e_bna = 0;
    end else begin
      case (m_ph)
        0: if (c_valid) begin e_rd = 1; e_addr = m_base + 32'(m_idx * 8); m_ph = 1; end
        1: begin e_rd = 0; m_snap = mem[e_addr[9:2]]; m_ph = 2; end
        2: if (m_snap[0]) begin
             e_bna = 1; e_rd = 1; m_ph = 1;
           end else begin
             e_bna = 0; e_wr = 1; e_addr = m_base + 32'(m_idx * 8 + 4);
             e_wd = {16'h0, c_last, c_first, (c_len > 14'd1536) ? 14'd1536 : c_len};
             m_ph = 3;
           end
        3: begin e_addr = m_base + 32'(m_idx * 8); e_wd = m_snap | 32'h1; e_rdy = 1; m_ph = 4; end
        default: begin
          e_wr = 0; e_rdy = 0;
          m_idx = (m_snap[1] || m_idx == 31) ? 0 : m_idx + 1;
          m_ph = 0;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(dm_rd == e_rd, "R2 read request", 32'(dm_rd), 32'(e_rd));
      chk(dm_wr == e_wr, e_addr[2] ? "R3 status write" : "R4 owner write", 32'(dm_wr), 32'(e_wr));
      if (e_rd || e_wr) chk(dm_addr == e_addr, "R6 descriptor address", dm_addr, e_addr);
      if (e_wr) chk(dm_wdata == e_wd, e_addr[2] ? "R3 status data" : "R4 owner data", dm_wdata, e_wd);
      chk(seg_ready == e_rdy, "R4 segment ready", 32'(seg_ready), 32'(e_rdy));
      chk(no_buf == e_bna, "R5 no buffer flag", 32'(no_buf), 32'(e_bna));
      chk(!(dm_rd && dm_wr), "R9 single access", {dm_rd, dm_wr}, 32'h0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic init_ring(input int base, input int n, input int wrap_at, input logic [31:0] buf0);
    for (int i = 0; i < n; i++) begin
      mem[(base >> 2) + 2 * i]     = ((buf0 + 32'(i * 1536)) & 32'hFFFF_FFFC) | ((i == wrap_at) ? 32'h2 : 32'h0);
      mem[(base >> 2) + 2 * i + 1] = 32'hF000_0000;
    end
  endtask

  task automatic send(input int len, input bit f, input bit l);
    c_valid = 1'b1; c_len = 14'(len); c_first = f; c_last = l;
    forever begin
      @(negedge clk);
      if (seg_ready) begin
        @(negedge clk);
        c_valid = 1'b0;
        break;
      end
    end
  endtask

  task automatic base_write(input logic [31:0] v);
    b_val = v; b_wr = 1'b1;
    @(negedge clk);
    b_wr = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    init_ring(0, 32, 99, 32'h0001_0000);
    init_ring(32'h200, 4, 3, 32'h0008_0000);
    mem[136] = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cmp_en = 1'b1;
    // R1 reset state
    chk(!dm_rd && !dm_wr && !seg_ready && !no_buf, "R1 idle after reset",
        {dm_rd, dm_wr, seg_ready, no_buf}, 32'h0);
    // R7 low base bits ignored
    base_write(32'h0000_0005);
    send(60, 1, 1);
    chk(mem[1] == 32'h0000_C03C, "R3 single segment status", mem[1], 32'h0000_C03C);
    chk(mem[0] == 32'h0001_0001, "R4 owner word R1 first at base", mem[0], 32'h0001_0001);
    // multi-descriptor frame
    send(1536, 1, 0);
    send(1536, 0, 0);
    send(100, 0, 1);
    chk(mem[3] == 32'h0000_4600, "R3 first segment flag", mem[3], 32'h0000_4600);
    chk(mem[5] == 32'h0000_0600, "R3 middle segment", mem[5], 32'h0000_0600);
    chk(mem[7] == 32'h0000_8064, "R3 last segment flag", mem[7], 32'h0000_8064);
    // R8 oversize length
    send(2000, 1, 1);
    chk(mem[9] == 32'h0000_C600, "R8 length clamp", mem[9], 32'h0000_C600);
    // fill remaining entries 5..31
    for (int i = 5; i < 32; i++) send(i, 1, 1);
    chk(mem[63] == 32'h0000_C01F, "R6 last entry written", mem[63], 32'h0000_C01F);
    // R6 depth wrap into a used entry 0, R5 stall
    c_valid = 1'b1; c_len = 14'd77; c_first = 1'b1; c_last = 1'b1;
    repeat (12) @(negedge clk);
    chk(no_buf == 1'b1, "R5 flag while owned", 32'(no_buf), 32'h1);
    chk(mem[1] == 32'h0000_C03C, "R5 owned descriptor untouched", mem[1], 32'h0000_C03C);
    mem[0] = mem[0] & 32'hFFFF_FFFE;
    forever begin
      @(negedge clk);
      if (seg_ready) begin @(negedge clk); c_valid = 1'b0; break; end
    end
    chk(mem[1] == 32'h0000_C04D, "R6 R5 wrapped write after release", mem[1], 32'h0000_C04D);
    chk(no_buf == 1'b0, "R5 flag cleared", 32'(no_buf), 32'h0);
    // R7 base write while stalled on owned entry 1
    c_valid = 1'b1; c_len = 14'd10; c_first = 1'b1; c_last = 1'b1;
    repeat (6) @(negedge clk);
    chk(no_buf == 1'b1, "R5 stalled before base write", 32'(no_buf), 32'h1);
    base_write(32'h0000_0200);
    chk(no_buf == 1'b0 && !dm_wr && !seg_ready, "R7 abort on base write",
        {no_buf, dm_wr, seg_ready}, 32'h0);
    forever begin
      @(negedge clk);
      if (seg_ready) begin @(negedge clk); c_valid = 1'b0; break; end
    end
    chk(mem[129] == 32'h0000_C00A, "R7 restart at new base", mem[129], 32'h0000_C00A);
    chk(mem[3] == 32'h0000_4600, "R7 old ring untouched", mem[3], 32'h0000_4600);
    // R6 wrap flag on short ring
    send(11, 1, 0);
    send(12, 0, 0);
    send(13, 0, 1);
    mem[128] = mem[128] & 32'hFFFF_FFFE;
    send(14, 1, 1);
    chk(mem[135] == 32'h0000_800D, "R6 flagged entry written", mem[135], 32'h0000_800D);
    chk(mem[134] == 32'h0008_1203, "R4 wrap flag kept", mem[134], 32'h0008_1203);
    chk(mem[129] == 32'h0000_C00E, "R6 wrap to base by flag", mem[129], 32'h0000_C00E);
    chk(mem[136] == 32'h1234_5678, "R6 no access past flagged entry", mem[136], 32'h1234_5678);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule